// File: doc/BRIEF.md
# Byte-Port Remote Register Access Sequencer

This block lets host logic read and write 32-bit registers that live on a coprocessor board which is reachable only through a byte-wide mailbox. Each request arrives on a valid/ready handshake carrying a write flag, an address and write data. The sequencer turns the request into a stream of bytes: an opcode byte, then the address, then the value for a write. For a read, it then collects a four-byte reply and returns it as one word.

Every byte waits for the mailbox flow-control flag that belongs to its direction. A send waits for "transmit empty" and a receive waits for "receive full". Each direction has its own time limit, counted in clock cycles and derived from the clock frequency parameter. When a limit runs out, the sequencer stops the access. It pulses an error, issues no further bytes and returns to idle. A successful access ends with a single done pulse.

Top module: `regport_seq`

## Requirements
- R1: A write request produces exactly nine mailbox writes: opcode 0x00, then the four address bytes, then the four data bytes. Each word goes least significant byte first. The write ends with one `rsp_done` pulse.
- R2: A read request produces five mailbox writes: opcode 0x01, then the four address bytes, least significant byte first. It then makes four mailbox reads. The first byte read becomes bits 7:0 of `rsp_rdata` and the fourth becomes bits 31:24. `rsp_rdata` is valid in the cycle of the `rsp_done` pulse.
- R3: `tx_strobe` is asserted only while `tx_empty` is 1, and never in two consecutive cycles. The mailbox must therefore reflect a write in its status by the next cycle.
- R4: `rx_strobe` is asserted only while `rx_full` is 1, and never in two consecutive cycles.
- R5: When `tx_empty` stays low for TX_LIMIT = 2*CLK_HZ waiting cycles, `rsp_timeout` pulses at the edge that is TX_LIMIT+1 cycles after the last mailbox write. `rsp_rdata` is then 0, no further byte is sent, and `req_ready` returns high.
- R6: When `rx_full` stays low for RX_LIMIT = CLK_HZ waiting cycles, `rsp_timeout` pulses at the edge that is RX_LIMIT+1 cycles after the last strobe. `rsp_rdata` then reads 0, and no further strobe follows.
- R7: `req_ready` is 1 only when the sequencer is idle. A request raised while an access is in progress is not taken, and it causes no bytes on the mailbox.
- R8: After reset, `req_ready` is 1 and `rsp_done`, `rsp_timeout`, `tx_strobe` and `rx_strobe` are 0. Each access ends with exactly one single-cycle pulse of either `rsp_done` or `rsp_timeout`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 32 | Remote register address |
| req_wdata | input | 32 | Value for a write |
| rsp_rdata | output | 32 | Read result (0 after a timeout) |
| rsp_done | output | 1 | One-cycle pulse: access completed |
| rsp_timeout | output | 1 | One-cycle pulse: access abandoned on a time limit |
| tx_empty | input | 1 | Mailbox output status bit 0: a byte may be written |
| tx_data | output | 8 | Byte for the mailbox data-in register |
| tx_strobe | output | 1 | Write `tx_data` into the mailbox this cycle |
| rx_full | input | 1 | Mailbox input status bit 0: a byte is waiting |
| rx_data | input | 8 | Byte from the mailbox data-out register |
| rx_strobe | output | 1 | Take `rx_data` from the mailbox this cycle |

## Verification
A wrong byte index shows up at once as a misplaced or missing byte in the mailbox log, and the access then ends with a wrong byte count. A timer that fails to clear, or that clears too often, moves the `rsp_timeout` pulse away from its exact expected edge, so the bench measures that edge from the last strobe. A sequencer that does not return to idle after an error shows extra strobes or a low `req_ready` within a few cycles of the pulse. The address and data patterns and the mailbox latencies are swept, so a swapped lane or a flag sampled during the settle cycle changes the log.

// File: rtl/regport_pkg.sv
package regport_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_RECV = 2'd2
    } seq_state_t;

    typedef struct packed {
        seq_state_t  st;
        logic [3:0]  idx;
        logic        gap;
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        done;
        logic        tmo;
        logic [31:0] rdata;
    } seq_regs_t;

    localparam logic [7:0] OP_WRITE = 8'h00;
    localparam logic [7:0] OP_READ  = 8'h01;
endpackage

// File: rtl/regport_timer.sv
module regport_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)      cnt_d = '0;
        else if (count) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == W'(LIMIT - 1));

    // R5 R6
    timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(LIMIT - 1));
endmodule

// File: rtl/regport_rxword.sv
module regport_rxword #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic [7:0]        byte_in,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] word_q, word_d;

    always_comb begin
        word_d = word_q;
        if (clear)      word_d = '0;
        else if (shift) word_d = {byte_in, word_q[WORD_W-1:8]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word = word_q;
endmodule

// File: rtl/regport_seq.sv
module regport_seq
    import regport_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int TX_LIMIT = 2 * CLK_HZ,
    parameter int RX_LIMIT = CLK_HZ
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic [31:0] rsp_rdata,
    output logic        rsp_done,
    output logic        rsp_timeout,
    input  logic        tx_empty,
    output logic [7:0]  tx_data,
    output logic        tx_strobe,
    input  logic        rx_full,
    input  logic [7:0]  rx_data,
    output logic        rx_strobe
);
    localparam logic [3:0] LAST_WR = 4'd8;
    localparam logic [3:0] LAST_RD = 4'd4;
    localparam logic [3:0] LAST_RX = 4'd3;

    seq_regs_t q, d;
    logic tmr_clr, tx_cnt, rx_cnt, tx_exp, rx_exp, asm_clr;
    logic [31:0] asm_word;
    logic [31:0] sel_word;
    logic [1:0]  lane;

    regport_timer #(.LIMIT(TX_LIMIT)) u_tx_tmr (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clr), .count(tx_cnt), .expired(tx_exp));

    regport_timer #(.LIMIT(RX_LIMIT)) u_rx_tmr (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clr), .count(rx_cnt), .expired(rx_exp));

    regport_rxword #(.WORD_W(32)) u_asm (
        .clk(clk), .rst_n(rst_n), .clear(asm_clr), .shift(rx_strobe),
        .byte_in(rx_data), .word(asm_word));

    // byte lane of the current outgoing word
    always_comb begin
        lane     = 2'(q.idx - 4'd1);
        sel_word = (q.idx <= 4'd4) ? q.addr : q.wdata;
        if (q.idx == 4'd0) tx_data = q.wr ? OP_WRITE : OP_READ;
        else               tx_data = sel_word[lane*8 +: 8];
    end

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.tmo     = 1'b0;
        tx_strobe = 1'b0;
        rx_strobe = 1'b0;
        tx_cnt    = 1'b0;
        rx_cnt    = 1'b0;
        tmr_clr   = 1'b0;
        asm_clr   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_SEND;
                    d.idx   = 4'd0;
                    d.gap   = 1'b0;
                    d.wr    = req_write;
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    tmr_clr = 1'b1;
                    asm_clr = 1'b1;
                end
            end
            ST_SEND: begin
                if (q.gap) begin
                    d.gap = 1'b0;
                end else if (tx_empty) begin
                    tx_strobe = 1'b1;
                    tmr_clr   = 1'b1;
                    d.gap     = 1'b1;
                    if (q.wr && q.idx == LAST_WR) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else if (!q.wr && q.idx == LAST_RD) begin
                        d.st  = ST_RECV;
                        d.idx = 4'd0;
                    end else begin
                        d.idx = q.idx + 4'd1;
                    end
                end else if (tx_exp) begin
                    d.st    = ST_IDLE;
                    d.tmo   = 1'b1;
                    d.rdata = '0;
                end else begin
                    tx_cnt = 1'b1;
                end
            end
            ST_RECV: begin
                if (q.gap) begin
                    d.gap = 1'b0;
                end else if (rx_full) begin
                    rx_strobe = 1'b1;
                    tmr_clr   = 1'b1;
                    d.gap     = 1'b1;
                    if (q.idx == LAST_RX) begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.rdata = {rx_data, asm_word[31:8]};
                    end else begin
                        d.idx = q.idx + 4'd1;
                    end
                end else if (rx_exp) begin
                    d.st    = ST_IDLE;
                    d.tmo   = 1'b1;
                    d.rdata = '0;
                end else begin
                    rx_cnt = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign rsp_rdata   = q.rdata;
    assign rsp_done    = q.done;
    assign rsp_timeout = q.tmo;

    // R3
    tx_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |=> !tx_strobe);
    // R4
    rx_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);
    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_done && rsp_timeout));
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R6
    tmo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> (rsp_rdata == 32'd0 && !tx_strobe && !rx_strobe));
    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/sim_regport_seq.sv
module sim_regport_seq;
    localparam int CLK_HZ = 10;
    localparam int TXL    = 2 * CLK_HZ;
    localparam int RXL    = CLK_HZ;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic req_ready, rsp_done, rsp_timeout, tx_strobe, rx_strobe;
    logic [31:0] rsp_rdata;
    logic [7:0] tx_data, rx_data;
    logic tx_empty, rx_full;

    always #2.5 clk = ~clk;

    regport_seq #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_timeout(rsp_timeout),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_strobe(tx_strobe),
        .rx_full(rx_full), .rx_data(rx_data), .rx_strobe(rx_strobe));

    // mailbox model
    int cyc = 0, t_tx = 0, t_rx = 0;
    int tx_n = 0, tx_wait = 0, rx_ptr = 0, rx_wait = 0, viol_n = 0;
    int tx_lat = 1, rx_lat = 1, tx_stop_at = 1 << 30, rx_avail = 0;
    logic [7:0] tx_log [0:2047];
    logic [7:0] rx_mem [0:2047];
    logic prev_tx = 1'b0, prev_rx = 1'b0;

    assign tx_empty = (tx_wait == 0);
    assign rx_full  = (rx_wait == 0) && (rx_ptr < rx_avail);
    assign rx_data  = rx_mem[rx_ptr[10:0]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        prev_tx <= tx_strobe;
        prev_rx <= rx_strobe;
        if ((tx_strobe && (!tx_empty || prev_tx)) || (rx_strobe && (!rx_full || prev_rx)))
            viol_n <= viol_n + 1;
        if (tx_strobe) begin
            tx_log[tx_n[10:0]] <= tx_data;
            tx_n <= tx_n + 1;
            tx_wait <= tx_lat;
            t_tx <= cyc;
        end else if (tx_wait != 0 && tx_n < tx_stop_at) begin
            tx_wait <= tx_wait - 1;
        end
        if (rx_strobe) begin
            rx_ptr <= rx_ptr + 1;
            rx_wait <= rx_lat;
            t_rx <= cyc;
        end else if (rx_wait != 0) begin
            rx_wait <= rx_wait - 1;
        end
    end

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_req(input bit wr, input logic [31:0] a, input logic [31:0] dv,
                           output bit got_done, output bit got_tmo, output logic [31:0] rd,
                           output int edge_at);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dv;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got_done = 1'b0; got_tmo = 1'b0; rd = '0; edge_at = 0;
        for (int k = 0; k < 400; k++) begin
            if (rsp_done || rsp_timeout) break;
            @(negedge clk);
        end
        got_done = rsp_done; got_tmo = rsp_timeout; rd = rsp_rdata; edge_at = cyc - 1;
    endtask

    function automatic logic [7:0] exp_byte(input bit wr, input logic [31:0] a,
                                            input logic [31:0] dv, input int i);
        if (i == 0) return wr ? 8'h00 : 8'h01;
        if (i <= 4) return a[(i-1)*8 +: 8];
        return dv[(i-5)*8 +: 8];
    endfunction

    function automatic bit frame_ok(input bit wr, input logic [31:0] a, input logic [31:0] dv,
                                    input int base, input int n);
        for (int i = 0; i < n; i++)
            if (tx_log[11'(base + i)] !== exp_byte(wr, a, dv, i)) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        bit dn, tm;
        logic [31:0] rd, a, dv, rw;
        int base, ed;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(req_ready === 1'b1 && rsp_done === 1'b0 && rsp_timeout === 1'b0 &&
              tx_strobe === 1'b0 && rx_strobe === 1'b0, "R8 reset",
              {59'd0, req_ready, rsp_done, rsp_timeout, tx_strobe, rx_strobe}, 64'h10);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 sweep over patterns and mailbox latencies
        for (int lt = 1; lt <= 3; lt++) begin
            for (int p = 0; p < 6; p++) begin
                tx_lat = lt; rx_lat = 4 - lt;
                a  = (32'h1357_9BDF * (p + 1)) ^ (32'h0F0F_0000 >> p);
                dv = ~a + 32'h0102_0304 * p;
                base = tx_n;
                run_req(1'b1, a, dv, dn, tm, rd, ed);
                check(dn && !tm, "R1 write done", {62'd0, dn, tm}, 64'h2);
                check(tx_n - base == 9 && frame_ok(1'b1, a, dv, base, 9), "R1 write frame",
                      64'(tx_n - base), 64'd9);
                rw = a ^ 32'hA5C3_0F96 ^ (32'h1111_1111 * lt);
                for (int k = 0; k < 4; k++) rx_mem[11'(rx_avail + k)] = rw[k*8 +: 8];
                rx_avail = rx_avail + 4;
                base = tx_n;
                run_req(1'b0, a, dv, dn, tm, rd, ed);
                check(dn && !tm && rd === rw, "R2 read data", {32'd0, rd}, {32'd0, rw});
                check(tx_n - base == 5 && frame_ok(1'b0, a, dv, base, 5), "R2 read frame",
                      64'(tx_n - base), 64'd5);
            end
        end
        check(viol_n == 0, "R3 R4 strobe gating", 64'(viol_n), 64'd0);

        // R7 request during busy
        tx_lat = 3;
        base = tx_n;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'hCAFE_0001; req_wdata = 32'h0BAD_F00D;
        @(posedge clk);
        @(negedge clk);
        req_addr = 32'h7777_7777; req_wdata = 32'h8888_8888;
        check(req_ready === 1'b0, "R7 ready low when busy", {63'd0, req_ready}, 64'd0);
        repeat (6) @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 100; k++) begin
            if (rsp_done) break;
            @(negedge clk);
        end
        repeat (8) @(negedge clk);
        check(tx_n - base == 9 && frame_ok(1'b1, 32'hCAFE_0001, 32'h0BAD_F00D, base, 9),
              "R7 busy request ignored", 64'(tx_n - base), 64'd9);

        // R5 transmit stalls mid-frame
        for (int s = 0; s < 3; s++) begin
            int k;
            bit wsel;
            k = (s == 0) ? 3 : (s == 1) ? 2 : 8;
            wsel = (s != 1);
            tx_lat = 2;
            base = tx_n;
            tx_stop_at = base + k;
            run_req(wsel, 32'h0000_5A00 + s, 32'h1234_5678, dn, tm, rd, ed);
            check(tm && !dn && rd === 32'd0, "R5 tx timeout flag", {31'd0, tm, dn, rd}, 64'h2_0000_0000);
            check(ed == t_tx + TXL + 1, "R5 tx timeout edge", 64'(ed), 64'(t_tx + TXL + 1));
            repeat (10) @(negedge clk);
            check(tx_n - base == k && req_ready === 1'b1, "R5 no bytes after timeout",
                  64'(tx_n - base), 64'(k));
            tx_stop_at = 1 << 30;
            repeat (4) @(negedge clk);
        end

        // R6 receive starves: no bytes, then two bytes only
        for (int s = 0; s < 2; s++) begin
            int ref_t;
            tx_lat = 1; rx_lat = 1;
            for (int k = 0; k < 2 * s; k++) rx_mem[11'(rx_avail + k)] = 8'h3C + 8'(k);
            rx_avail = rx_avail + 2 * s;
            run_req(1'b0, 32'hF00D_0000 + s, 32'd0, dn, tm, rd, ed);
            ref_t = (s == 0) ? t_tx : t_rx;
            check(tm && !dn && rd === 32'd0, "R6 rx timeout reads zero", {31'd0, tm, dn, rd}, 64'h2_0000_0000);
            check(ed == ref_t + RXL + 1, "R6 rx timeout edge", 64'(ed), 64'(ref_t + RXL + 1));
            @(negedge clk);
            check(rsp_timeout === 1'b0 && req_ready === 1'b1, "R8 single pulse",
                  {62'd0, rsp_timeout, req_ready}, 64'd1);
        end
        check(rx_ptr == rx_avail, "R4 reads match supplied bytes", 64'(rx_ptr), 64'(rx_avail));
        check(viol_n == 0, "R3 R4 strobe gating final", 64'(viol_n), 64'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule